// File: doc/BRIEF.md
# I2C Transmit FIFO Streamer

This block sits between a register interface and an I2C byte engine. Software turns on the queue and pushes bytes into it through a data register. The streamer then hands those bytes to the byte engine one at a time, in the order they were written. It waits for each byte's acknowledge phase before it launches the next one.

A drained queue raises a transmit-empty interrupt flag. A live empty flag is also shown in a FIFO status byte. When the engine reports a not-acknowledge, the streamer sets a NAK flag and stops. Any bytes not yet sent stay in the queue. Only a flush command returns the streamer to service.

A flush issued while a byte is on the bus is held back until that byte completes. A write to a full queue is dropped and sets an overflow flag. The interrupt flags are sticky and are cleared by writing ones.

Top module: `i2c_txfifo_streamer`

## Requirements
- R1: After reset the enable bit reads 0, all interrupt flags read 0, the FIFO status empty flag (bit 4) reads 1 and no engine start is issued.
- R2: A control write sets the enable from data bit 6; the control readback shows the enable in bit 6, and bit 7 (flush) always reads 0 because it is a command, not a state.
- R3: A data write while enabled queues one byte; a data write while disabled is ignored, so nothing is sent later and the empty flag stays 1.
- R4: Queued bytes go to the engine in write order, each as a one-cycle start pulse with the byte value; the first start appears two clock edges after the write into an idle, empty queue.
- R5: At most one byte is in flight: no new start is issued until the engine's done pulse for the previous byte, and the next start comes at the second edge after that done.
- R6: Interrupt flag bit 1 (transmit empty) is set on the edge where a byte is acknowledged while no other byte is queued. FIFO status bit 4 reads 1 exactly when the queue holds no byte and no byte is in flight.
- R7: A done pulse with NAK set sets interrupt flag bit 0 and halts draining; the remaining bytes stay queued, so the empty flag stays 0 and no start is issued until a flush.
- R8: A flush while no byte is in flight empties the queue and clears the halt at the same edge; new writes are then sent normally.
- R9: A flush while a byte is in flight lets that byte finish, and empties the queue at the edge of its done pulse; no further byte of the old queue is sent.
- R10: The queue holds 64 bytes. A data write while enabled and full is dropped and sets interrupt flag bit 2.
- R11: Writing a 1 to an interrupt flag bit clears it; in a cycle where the same flag is also being set, the set wins.
- R12: Clearing the enable stops new launches; a byte already in flight still completes, and the queued bytes are sent once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 6 enable, bit 7 flush |
| ctrl_rdata | output | 8 | Control readback: bit 6 enable |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte to queue |
| irq_clr_wr | input | 1 | Interrupt flag clear strobe |
| irq_clr_mask | input | 8 | Ones clear the matching flags |
| irq_flags | output | 8 | Bit 0 NAK, bit 1 transmit empty, bit 2 overflow |
| fifo_flags | output | 8 | Bit 4 queue empty and idle |
| eng_start | output | 1 | One-cycle launch of a byte to the engine |
| eng_byte | output | 8 | Byte being launched |
| eng_done | input | 1 | Engine finished the acknowledge phase |
| eng_nak | input | 1 | Valid with eng_done: byte was not acknowledged |

## Verification
Each result has a fixed due time relative to its cause. A start pulse appears two edges after the write that fills an idle queue, and two edges after the done pulse that frees the engine. Interrupt flags and the empty flag change on the edge that samples the done pulse, the flush command, or the rejected write. The bench holds a behavioural model with a queue that advances on the same edges. It compares the start pulse, the launched byte, every flag and the control readback at each falling edge. On top of this, scenario checks confirm the order and count of delivered bytes, and that nothing is launched while the streamer is disabled, halted or flushing.

// File: rtl/txs_pkg.sv
// Package: shared bit positions and state type for the transmit streamer.
// Assumes 8-bit register views; positions are fixed by software decoding.
package txs_pkg;
    localparam int CTRL_EN_BIT    = 6;
    localparam int CTRL_FLUSH_BIT = 7;
    localparam int IRQ_NAK_BIT    = 0;
    localparam int IRQ_TXE_BIT    = 1;
    localparam int IRQ_OVF_BIT    = 2;
    localparam int FST_EMPTY_BIT  = 4;
    localparam int REG_W          = 8;

    typedef enum logic [0:0] {
        DRN_IDLE = 1'b0,
        DRN_BUSY = 1'b1
    } drain_state_t;
endpackage

// File: rtl/txs_fifo_store.sv
// Byte queue storage: circular buffer with read/write pointers and a count.
// Assumes the caller never pushes when full nor pops when empty; clear has
// priority over push and pop in the same cycle.
module txs_fifo_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              clear,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the pushed byte into storage.
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Maintain pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH))); // R10
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R8
endmodule

// File: rtl/txs_drain_ctrl.sv
// Drain sequencer: launches one queued byte at a time to the byte engine,
// waits for its done pulse, halts on NAK and performs (or defers) flushes.
// Assumes eng_done is a single-cycle pulse and eng_nak is valid with it.
module txs_drain_ctrl
    import txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              flush_req,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    input  logic              eng_done,
    input  logic              eng_nak,
    output logic              q_pop,
    output logic              q_clear,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_byte,
    output logic              busy,
    output logic              ack_ev,
    output logic              nak_ev
);
    drain_state_t state;
    logic         halted;
    logic         flush_pend;
    logic         done_ev;
    logic         launch;

    assign busy    = (state == DRN_BUSY);
    assign done_ev = busy && eng_done;
    assign ack_ev  = done_ev && !eng_nak;
    assign nak_ev  = done_ev && eng_nak;
    assign q_clear = (flush_req && !busy) || (done_ev && (flush_pend || flush_req));
    assign launch  = !busy && fifo_en && !q_empty && !halted && !flush_req;
    assign q_pop   = launch;

    // Track whether a byte is on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DRN_IDLE;
        end else if (launch) begin
            state <= DRN_BUSY;
        end else if (done_ev) begin
            state <= DRN_IDLE;
        end
    end

    // Register the one-cycle start pulse and the launched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_byte  <= '0;
        end else begin
            eng_start <= launch;
            if (launch) eng_byte <= q_head;
        end
    end

    // Halt on NAK until a flush completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (q_clear) begin
            halted <= 1'b0;
        end else if (nak_ev) begin
            halted <= 1'b1;
        end
    end

    // Remember a flush requested while a byte is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pend <= 1'b0;
        end else if (q_clear) begin
            flush_pend <= 1'b0;
        end else if (flush_req && busy) begin
            flush_pend <= 1'b1;
        end
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> !eng_start); // R5
    AST_HALT_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !eng_start); // R7
    AST_FLUSH_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend |=> !eng_start); // R9
    AST_DISABLED_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !eng_start); // R12
endmodule

// File: rtl/txs_status_regs.sv
// Register views: enable bit, self-clearing flush command, sticky
// write-one-to-clear interrupt flags and the live FIFO status byte.
// Assumes the event inputs are single-cycle pulses from the sequencer.
module txs_status_regs
    import txs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             data_wr,
    input  logic             irq_clr_wr,
    input  logic [REG_W-1:0] irq_clr_mask,
    input  logic             q_full,
    input  logic             q_empty,
    input  logic             busy,
    input  logic             ack_ev,
    input  logic             nak_ev,
    output logic             fifo_en,
    output logic             flush_req,
    output logic             push,
    output logic [REG_W-1:0] ctrl_rdata,
    output logic [REG_W-1:0] irq_flags,
    output logic [REG_W-1:0] fifo_flags
);
    logic       nak_q;
    logic       txe_q;
    logic       ovf_q;
    logic       ovf_ev;
    logic       txe_ev;
    logic [2:0] clr;
    logic       unused_bits;

    assign unused_bits = ^{ctrl_wdata[5:0], irq_clr_mask[REG_W-1:3]};
    assign flush_req   = ctrl_wr && ctrl_wdata[CTRL_FLUSH_BIT];
    assign push        = data_wr && fifo_en && !q_full;
    assign ovf_ev      = data_wr && fifo_en && q_full;
    assign txe_ev      = ack_ev && q_empty;
    assign clr         = irq_clr_wr ? irq_clr_mask[2:0] : 3'b000;

    // Hold the enable bit from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
        end else if (ctrl_wr) begin
            fifo_en <= ctrl_wdata[CTRL_EN_BIT];
        end
    end

    // Sticky interrupt flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_q <= 1'b0;
            txe_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            nak_q <= nak_ev || (nak_q && !clr[IRQ_NAK_BIT]);
            txe_q <= txe_ev || (txe_q && !clr[IRQ_TXE_BIT]);
            ovf_q <= ovf_ev || (ovf_q && !clr[IRQ_OVF_BIT]);
        end
    end

    // Assemble the read views.
    always_comb begin
        ctrl_rdata                = '0;
        ctrl_rdata[CTRL_EN_BIT]   = fifo_en;
        irq_flags                 = '0;
        irq_flags[IRQ_NAK_BIT]    = nak_q;
        irq_flags[IRQ_TXE_BIT]    = txe_q;
        irq_flags[IRQ_OVF_BIT]    = ovf_q;
        fifo_flags                = '0;
        fifo_flags[FST_EMPTY_BIT] = q_empty && !busy;
    end

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && fifo_en && q_full) |=> irq_flags[IRQ_OVF_BIT]); // R10
    AST_NAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        nak_ev |=> irq_flags[IRQ_NAK_BIT]); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_wr && irq_clr_mask[IRQ_TXE_BIT] && !txe_ev) |=> !irq_flags[IRQ_TXE_BIT]); // R11
endmodule

// File: rtl/i2c_txfifo_streamer.sv
// Transmit FIFO streamer: queues bytes written while enabled and drains them
// to an I2C byte engine one acknowledge phase at a time.
// Assumes the byte engine owns all bus signalling and reports done/nak.
module i2c_txfifo_streamer
    import txs_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    output logic [REG_W-1:0] ctrl_rdata,
    input  logic             data_wr,
    input  logic [REG_W-1:0] data_wdata,
    input  logic             irq_clr_wr,
    input  logic [REG_W-1:0] irq_clr_mask,
    output logic [REG_W-1:0] irq_flags,
    output logic [REG_W-1:0] fifo_flags,
    output logic             eng_start,
    output logic [REG_W-1:0] eng_byte,
    input  logic             eng_done,
    input  logic             eng_nak
);
    logic             fifo_en;
    logic             flush_req;
    logic             push;
    logic             pop;
    logic             clear;
    logic             q_full;
    logic             q_empty;
    logic [REG_W-1:0] q_head;
    logic             busy;
    logic             ack_ev;
    logic             nak_ev;

    txs_fifo_store #(.DEPTH(DEPTH), .DATA_W(REG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (data_wdata),
        .pop       (pop),
        .clear     (clear),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty)
    );

    txs_drain_ctrl #(.DATA_W(REG_W)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .flush_req (flush_req),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .eng_done  (eng_done),
        .eng_nak   (eng_nak),
        .q_pop     (pop),
        .q_clear   (clear),
        .eng_start (eng_start),
        .eng_byte  (eng_byte),
        .busy      (busy),
        .ack_ev    (ack_ev),
        .nak_ev    (nak_ev)
    );

    txs_status_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .data_wr      (data_wr),
        .irq_clr_wr   (irq_clr_wr),
        .irq_clr_mask (irq_clr_mask),
        .q_full       (q_full),
        .q_empty      (q_empty),
        .busy         (busy),
        .ack_ev       (ack_ev),
        .nak_ev       (nak_ev),
        .fifo_en      (fifo_en),
        .flush_req    (flush_req),
        .push         (push),
        .ctrl_rdata   (ctrl_rdata),
        .irq_flags    (irq_flags),
        .fifo_flags   (fifo_flags)
    );

    AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flags[FST_EMPTY_BIT] && !data_wr) |=> !eng_start); // R6
endmodule

// File: tb/i2c_txfifo_streamer_bench.sv
module i2c_txfifo_streamer_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       irq_clr_wr = 1'b0;
    logic [7:0] irq_clr_mask = '0;
    logic [7:0] irq_flags;
    logic [7:0] fifo_flags;
    logic       eng_start;
    logic [7:0] eng_byte;
    logic       eng_done = 1'b0;
    logic       eng_nak = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    i2c_txfifo_streamer #(.DEPTH(DEPTH)) u_i2c_txfifo_streamer (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .irq_clr_wr(irq_clr_wr), .irq_clr_mask(irq_clr_mask),
        .irq_flags(irq_flags), .fifo_flags(fifo_flags),
        .eng_start(eng_start), .eng_byte(eng_byte),
        .eng_done(eng_done), .eng_nak(eng_nak)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model state, advanced on each rising edge.
    bit       m_en, m_busy, m_halt, m_pend, m_start;
    bit       m_nak, m_txe, m_ovf;
    bit [7:0] m_byte;
    bit [7:0] m_q[$];

    always @(posedge clk) begin
        bit flush, done_ev, clr, full, qe, launch;
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_halt = 0; m_pend = 0; m_start = 0;
            m_nak = 0; m_txe = 0; m_ovf = 0; m_q.delete();
        end else begin
            flush   = ctrl_wr && ctrl_wdata[7];
            done_ev = m_busy && eng_done;
            clr     = (flush && !m_busy) || (done_ev && (m_pend || flush));
            full    = (m_q.size() == DEPTH);
            qe      = (m_q.size() == 0);
            launch  = !m_busy && m_en && !qe && !m_halt && !flush;
            m_nak = (done_ev && eng_nak) || (m_nak && !(irq_clr_wr && irq_clr_mask[0]));
            m_txe = (done_ev && !eng_nak && qe) || (m_txe && !(irq_clr_wr && irq_clr_mask[1]));
            m_ovf = (data_wr && m_en && full) || (m_ovf && !(irq_clr_wr && irq_clr_mask[2]));
            if (clr) m_q.delete();
            else begin
                if (launch) m_byte = m_q.pop_front();
                if (data_wr && m_en && !full) m_q.push_back(data_wdata);
            end
            m_start = launch;
            if (clr) m_pend = 0; else if (flush && m_busy) m_pend = 1;
            if (clr) m_halt = 0; else if (done_ev && eng_nak) m_halt = 1;
            if (launch) m_busy = 1; else if (done_ev) m_busy = 0;
            if (ctrl_wr) m_en = ctrl_wdata[6];
        end
    end

    // Byte engine responder and per-cycle comparison.
    int       lat = 2;
    bit       rsp_busy = 0;
    int       rsp_cnt = 0;
    bit       nak_q[$];
    bit [7:0] sent[$];

    always @(negedge clk) begin
        if (cyc > 0) begin
            chk(eng_start == m_start, "R4 start", eng_start, m_start);
            if (m_start) chk(eng_byte == m_byte, "R4 byte", eng_byte, m_byte);
            chk(irq_flags[0] == m_nak, "R7 nak flag", irq_flags[0], m_nak);
            chk(irq_flags[1] == m_txe, "R6 txe flag", irq_flags[1], m_txe);
            chk(irq_flags[2] == m_ovf, "R10 ovf flag", irq_flags[2], m_ovf);
            chk(fifo_flags == {3'b0, (m_q.size() == 0 && !m_busy), 4'b0}, "R6 fifo flags",
                fifo_flags, {3'b0, (m_q.size() == 0 && !m_busy), 4'b0});
            chk(ctrl_rdata == {1'b0, m_en, 6'b0}, "R2 ctrl readback", ctrl_rdata, {1'b0, m_en, 6'b0});
        end
        eng_done = 0;
        eng_nak  = 0;
        if (eng_start) begin
            chk(!rsp_busy, "R5 start while in flight", 1, 0);
            sent.push_back(eng_byte);
            rsp_busy = 1;
            rsp_cnt  = lat;
        end else if (rsp_busy) begin
            if (rsp_cnt == 0) begin
                eng_done = 1;
                eng_nak  = (nak_q.size() > 0) ? nak_q.pop_front() : 1'b0;
                rsp_busy = 0;
            end else begin
                rsp_cnt--;
            end
        end
    end

    task automatic ctrl(input bit en, input bit fl);
        @(negedge clk);
        ctrl_wr = 1; ctrl_wdata = {fl, en, 6'b0};
        @(negedge clk);
        ctrl_wr = 0; ctrl_wdata = '0;
    endtask

    task automatic push_bytes(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            data_wr = 1; data_wdata = 8'(base + i);
        end
        @(negedge clk);
        data_wr = 0;
    endtask

    task automatic clr_flags(input bit [7:0] m);
        @(negedge clk);
        irq_clr_wr = 1; irq_clr_mask = m;
        @(negedge clk);
        irq_clr_wr = 0; irq_clr_mask = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state.
        chk(ctrl_rdata == 8'h00 && irq_flags == 8'h00, "R1 reset regs", {ctrl_rdata, irq_flags}, 0);
        chk(fifo_flags == 8'h10 && !eng_start, "R1 reset empty", fifo_flags, 8'h10);

        // R3: writes while disabled are dropped.
        push_bytes(8'h30, 3);
        ctrl(1, 0);
        idle(20);
        chk(sent.size() == 0, "R3 disabled writes ignored", sent.size(), 0);
        chk(fifo_flags[4] == 1, "R3 empty after ignored writes", fifo_flags[4], 1);
        // R2: flush bit reads back as zero.
        chk(ctrl_rdata == 8'h40, "R2 enable readback", ctrl_rdata, 8'h40);

        // R4/R6: basic ordered stream.
        lat = 3;
        push_bytes(8'hA0, 5);
        idle(60);
        chk(sent.size() == 5, "R4 byte count", sent.size(), 5);
        for (int i = 0; i < sent.size(); i++)
            chk(sent[i] == 8'(8'hA0 + i), "R4 order", sent[i], 8'hA0 + i);
        chk(irq_flags[1] == 1, "R6 txe set after drain", irq_flags[1], 1);

        // R11: write-one-to-clear.
        clr_flags(8'h02);
        chk(irq_flags[1] == 0, "R11 txe cleared", irq_flags[1], 0);

        // R7: NAK halts with bytes left.
        sent.delete();
        nak_q.push_back(0); nak_q.push_back(1);
        push_bytes(8'h50, 4);
        idle(60);
        chk(sent.size() == 2, "R7 halted after nak", sent.size(), 2);
        chk(irq_flags[0] == 1, "R7 nak flag set", irq_flags[0], 1);
        chk(fifo_flags[4] == 0, "R7 bytes remain queued", fifo_flags[4], 0);

        // R8: idle flush empties and resumes.
        ctrl(1, 1);
        chk(fifo_flags[4] == 1, "R8 empty after flush", fifo_flags[4], 1);
        clr_flags(8'h07);
        sent.delete();
        push_bytes(8'h60, 2);
        idle(40);
        chk(sent.size() == 2 && sent[0] == 8'h60, "R8 resumes after flush", sent.size(), 2);

        // R9: flush while a byte is in flight.
        sent.delete();
        lat = 20;
        push_bytes(8'h70, 3);
        ctrl(1, 1);
        chk(fifo_flags[4] == 0, "R9 flush deferred while busy", fifo_flags[4], 0);
        idle(60);
        chk(sent.size() == 1, "R9 only in-flight byte sent", sent.size(), 1);
        chk(fifo_flags[4] == 1, "R9 empty after deferred flush", fifo_flags[4], 1);

        // R10: overflow at 64 queued plus one in flight.
        sent.delete();
        lat = 200;
        push_bytes(0, DEPTH + 3);
        lat = 1;
        chk(irq_flags[2] == 1, "R10 overflow flag", irq_flags[2], 1);
        idle(600);
        chk(sent.size() == DEPTH + 1, "R10 accepted bytes", sent.size(), DEPTH + 1);
        clr_flags(8'h07);

        // R12: disable mid-transfer.
        sent.delete();
        lat = 10;
        push_bytes(8'h90, 3);
        ctrl(0, 0);
        idle(60);
        n0 = sent.size();
        chk(n0 == 1, "R12 stop after in-flight byte", n0, 1);
        ctrl(1, 0);
        idle(80);
        chk(sent.size() == 3 && sent[2] == 8'h92, "R12 resume after enable", sent.size(), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule